// File: doc/BRIEF.md
# Configurable Framed Serial Byte Receiver

This block turns a bit stream into bytes. The bits come from one channel of a time-division stream that has already been picked out upstream. Each bit arrives with a single-cycle valid strobe, and the block assembles eight of them, least significant bit first, into a byte. It hands the byte out with a one-cycle write strobe, ready to be pushed into a downstream store. A run-time control chooses between two forms of the stream. In the first, bytes are framed: each byte opens with a low start bit, may carry a parity bit after its data, and closes with a stop bit. In the second, the stream is raw: bits are packed into bytes straight after the receiver is armed, with no framing.

In framed operation the receiver waits for the first low bit after it is enabled, treats that bit as the start bit, then collects the data bits, the optional parity bit and the stop bit. After the stop bit it goes back to waiting for the next start bit. Parity is even by default and can be switched to odd. A parity mismatch or a low stop bit raises a flag that pulses together with the byte strobe. In raw operation no parity bit is consumed and no parity check is made, even when parity is enabled. Dropping the enable returns the receiver to idle on the next edge and throws away any byte still in progress.

Top module: `ser_byte_rx`

## Requirements
- R1: After reset, byte_vld_o, par_err_o, stop_err_o and busy_o are 0 and byte_o is 0x00.
- R2: With frame_en_i=1, while waiting for a start bit, bits equal to 1 are ignored. The first 0 bit is the start bit, the next 8 bits are data (first received bit lands in byte_o[0]), then the stop bit follows. byte_vld_o is 1 for exactly one cycle, on the clock after the edge that accepts the stop bit.
- R3: With frame_en_i=1 and par_en_i=1, one parity bit sits between the data bits and the stop bit. The check is even parity when par_odd_i=0 (the data ones plus the parity bit add up to an even count) and odd parity when par_odd_i=1. A mismatch sets par_err_o=1 in the byte_vld_o cycle of that byte.
- R4: With frame_en_i=1, a stop bit of 0 sets stop_err_o=1 in the byte_vld_o cycle, and the byte is still delivered.
- R5: With frame_en_i=1, after the stop bit the receiver waits for the next 0 start bit, so frames separated by any number of idle 1 bits are each received.
- R6: With frame_en_i=0, bits are packed into bytes starting with the first valid bit after enable. A byte is delivered every 8 bits with no gaps. par_err_o and stop_err_o stay 0 whatever the value of par_en_i.
- R7: When en_i=0, busy_o and byte_vld_o are 0 on the next cycle and any partial byte is dropped. After re-enable, the next byte is built only from bits received after re-enable.
- R8: Bits presented while bit_vld_i=0 have no effect, including a 0 on bit_i while waiting for a start bit.
- R9: In framed operation busy_o is 1 from the cycle after the start bit is accepted until the edge that accepts the stop bit, and 0 while waiting for a start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Receiver enable; low forces idle |
| frame_en_i | input | 1 | 1: start/stop framing, 0: raw bits |
| par_en_i | input | 1 | 1: parity bit expected in framed operation |
| par_odd_i | input | 1 | 0: even parity, 1: odd parity |
| bit_vld_i | input | 1 | Strobe qualifying bit_i |
| bit_i | input | 1 | Serial bit |
| byte_o | output | 8 | Received byte |
| byte_vld_o | output | 1 | One-cycle strobe for byte_o |
| par_err_o | output | 1 | Parity mismatch, with byte_vld_o |
| stop_err_o | output | 1 | Stop bit was 0, with byte_vld_o |
| busy_o | output | 1 | A byte is in progress |

## Verification
The parity check and the stop-bit check are both judged on the same byte, so both flags can rise in one byte_vld_o cycle. The bench provokes this by sending a frame with a wrong parity bit and a 0 stop bit. It expects both flags high, the byte intact, and the receiver back at hunting, which it confirms by receiving a clean frame right after. It also crosses the raw mode with parity enabled, where neither flag may appear.

// File: rtl/ser_rx_pkg.sv
package ser_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HUNT,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;
endpackage

// File: rtl/rx_shift.sv
module rx_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic [DATA_W-1:0] data_nxt_o
);
  logic [DATA_W-1:0] data_q;

  // LSB first: the newest bit enters at the top
  assign data_nxt_o = shift_i ? {bit_i, data_q[DATA_W-1:1]} : data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) data_q <= '0;
    else         data_q <= data_nxt_o;
  end
endmodule

// File: rtl/rx_ctrl.sv
module rx_ctrl
  import ser_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic frame_en_i,
  input  logic par_en_i,
  input  logic bit_vld_i,
  input  logic bit_i,
  output logic shift_o,
  output logic par_cap_o,
  output logic stop_chk_o,
  output logic done_o,
  output logic busy_o
);
  localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  rx_state_e st_q, st_d, st_eff;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  // idle resolves straight into the armed state so the first enabled bit counts
  assign st_eff = (st_q == ST_IDLE) ? (frame_en_i ? ST_HUNT : ST_DATA) : st_q;

  always_comb begin
    st_d       = st_eff;
    cnt_d      = cnt_q;
    shift_o    = 1'b0;
    par_cap_o  = 1'b0;
    stop_chk_o = 1'b0;
    done_o     = 1'b0;
    if (!en_i) begin
      st_d  = ST_IDLE;
      cnt_d = '0;
    end else if (bit_vld_i) begin
      unique case (st_eff)
        ST_HUNT: begin
          if (!bit_i) begin
            st_d  = ST_DATA;
            cnt_d = '0;
          end
        end
        ST_DATA: begin
          shift_o = 1'b1;
          if (cnt_q == LAST) begin
            cnt_d = '0;
            if (frame_en_i) st_d = par_en_i ? ST_PAR : ST_STOP;
            else            done_o = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_PAR: begin
          par_cap_o = 1'b1;
          st_d      = ST_STOP;
        end
        ST_STOP: begin
          stop_chk_o = 1'b1;
          done_o     = 1'b1;
          st_d       = ST_HUNT;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign busy_o = (st_q == ST_DATA) || (st_q == ST_PAR) || (st_q == ST_STOP);
endmodule

// File: rtl/ser_byte_rx.sv
module ser_byte_rx #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              frame_en_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              bit_vld_i,
  input  logic              bit_i,
  output logic [DATA_W-1:0] byte_o,
  output logic              byte_vld_o,
  output logic              par_err_o,
  output logic              stop_err_o,
  output logic              busy_o
);
  logic              shift, par_cap, stop_chk, done;
  logic [DATA_W-1:0] data_nxt;
  logic              par_bit_q;
  logic [DATA_W-1:0] byte_q;
  logic              vld_q, perr_q, serr_q;

  rx_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .frame_en_i (frame_en_i),
    .par_en_i   (par_en_i),
    .bit_vld_i  (bit_vld_i),
    .bit_i      (bit_i),
    .shift_o    (shift),
    .par_cap_o  (par_cap),
    .stop_chk_o (stop_chk),
    .done_o     (done),
    .busy_o     (busy_o)
  );

  rx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shift_i    (shift),
    .bit_i      (bit_i),
    .data_nxt_o (data_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      par_bit_q <= 1'b0;
      byte_q    <= '0;
      vld_q     <= 1'b0;
      perr_q    <= 1'b0;
      serr_q    <= 1'b0;
    end else begin
      if (par_cap) par_bit_q <= bit_i;
      if (done)    byte_q    <= data_nxt;
      vld_q  <= done;
      // stop_chk only occurs in framed operation, so raw mode never flags
      perr_q <= stop_chk & par_en_i & (^data_nxt ^ par_bit_q ^ par_odd_i);
      serr_q <= stop_chk & ~bit_i;
    end
  end

  assign byte_o     = byte_q;
  assign byte_vld_o = vld_q;
  assign par_err_o  = perr_q;
  assign stop_err_o = serr_q;
endmodule

// File: rtl/ser_byte_rx_chk.sv
module ser_byte_rx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic frame_en_i,
  input logic bit_vld_i,
  input logic byte_vld_o,
  input logic par_err_o,
  input logic stop_err_o,
  input logic busy_o
);
  a_r3_perr_with_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_err_o |-> byte_vld_o);

  a_r4_serr_with_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_err_o |-> byte_vld_o);

  a_r6_raw_no_perr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_en_i |=> !par_err_o);

  a_r6_raw_no_serr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_en_i |=> !stop_err_o);

  a_r7_disable_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!busy_o && !byte_vld_o));

  a_r8_byte_needs_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_vld_i |=> !byte_vld_o);
endmodule

bind ser_byte_rx ser_byte_rx_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .frame_en_i (frame_en_i),
  .bit_vld_i  (bit_vld_i),
  .byte_vld_o (byte_vld_o),
  .par_err_o  (par_err_o),
  .stop_err_o (stop_err_o),
  .busy_o     (busy_o)
);

// File: tb/sim_ser_byte_rx.sv
module sim_ser_byte_rx;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0, frame_en = 1'b1, par_en = 1'b0, par_odd = 1'b0;
  logic       bit_vld = 1'b0, bit_d = 1'b1;
  logic [7:0] byte_o;
  logic       byte_vld, par_err, stop_err, busy;

  int checks = 0, errors = 0;
  int nbytes = 0;
  logic [7:0] last_byte;
  logic last_pe, last_se;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ser_byte_rx u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .frame_en_i(frame_en),
    .par_en_i(par_en), .par_odd_i(par_odd), .bit_vld_i(bit_vld), .bit_i(bit_d),
    .byte_o(byte_o), .byte_vld_o(byte_vld), .par_err_o(par_err),
    .stop_err_o(stop_err), .busy_o(busy)
  );

  // capture every delivered byte, sampled after the edge
  always @(posedge clk) begin
    #1;
    if (byte_vld) begin
      nbytes++;
      last_byte = byte_o;
      last_pe   = par_err;
      last_se   = stop_err;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(logic b);
    @(negedge clk);
    bit_vld = 1'b1;
    bit_d   = b;
    @(negedge clk);
    bit_vld = 1'b0;
    bit_d   = 1'b1;
  endtask

  task automatic send_data(logic [7:0] v);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
  endtask

  task automatic send_frame(logic [7:0] v, logic with_par, logic pbit, logic stop);
    send_bit(1'b0);
    send_data(v);
    if (with_par) send_bit(pbit);
    send_bit(stop);
  endtask

  task automatic set_mode(logic fr, logic pe, logic po);
    @(negedge clk);
    en = 1'b0;
    frame_en = fr; par_en = pe; par_odd = po;
    @(negedge clk);
    en = 1'b1;
  endtask

  task automatic t_reset;
    chk("R1 byte_vld", byte_vld, 0);
    chk("R1 flags", {par_err, stop_err}, 0);
    chk("R1 busy", busy, 0);
    chk("R1 byte", byte_o, 8'h00);
  endtask

  task automatic t_framed_basic;
    int n0;
    set_mode(1, 0, 0);
    n0 = nbytes;
    send_bit(1); send_bit(1);
    chk("R2 idle ones ignored", busy, 0);
    send_bit(0);
    chk("R9 busy after start", busy, 1);
    send_data(8'hA5);
    chk("R9 busy before stop", busy, 1);
    send_bit(1);
    chk("R9 busy after stop", busy, 0);
    chk("R2 one byte", nbytes - n0, 1);
    chk("R2 byte value", last_byte, 8'hA5);
    chk("R2 no errors", {last_pe, last_se}, 0);
  endtask

  task automatic t_back_to_back;
    int n0;
    set_mode(1, 0, 0);
    n0 = nbytes;
    send_frame(8'h3C, 0, 0, 1);
    chk("R5 first byte", last_byte, 8'h3C);
    send_frame(8'h81, 0, 0, 1);
    chk("R5 second immediate", last_byte, 8'h81);
    send_bit(1); send_bit(1); send_bit(1);
    send_frame(8'h00, 0, 0, 1);
    chk("R5 after idle", last_byte, 8'h00);
    chk("R5 count", nbytes - n0, 3);
  endtask

  task automatic t_parity;
    set_mode(1, 1, 0);
    send_frame(8'h07, 1, 1, 1);
    chk("R3 even ok", {last_byte, last_pe}, {8'h07, 1'b0});
    send_frame(8'h07, 1, 0, 1);
    chk("R3 even mismatch", {last_byte, last_pe}, {8'h07, 1'b1});
    send_frame(8'h00, 1, 0, 1);
    chk("R3 even zero ok", last_pe, 0);
    set_mode(1, 1, 1);
    send_frame(8'h07, 1, 0, 1);
    chk("R3 odd ok", last_pe, 0);
    send_frame(8'h07, 1, 1, 1);
    chk("R3 odd mismatch", last_pe, 1);
  endtask

  task automatic t_stop_err;
    set_mode(1, 0, 0);
    send_frame(8'h5E, 0, 0, 0);
    chk("R4 stop err", {last_byte, last_se, last_pe}, {8'h5E, 1'b1, 1'b0});
    // both checks fail on the same byte
    set_mode(1, 1, 0);
    send_frame(8'h01, 1, 0, 0);
    chk("R3 R4 both flags", {last_byte, last_pe, last_se}, {8'h01, 1'b1, 1'b1});
    send_frame(8'h03, 1, 0, 1);
    chk("R5 clean after errors", {last_byte, last_pe, last_se}, {8'h03, 1'b0, 1'b0});
  endtask

  task automatic t_raw;
    int n0;
    set_mode(0, 1, 0);
    n0 = nbytes;
    send_data(8'hF0);
    chk("R6 raw first byte", last_byte, 8'hF0);
    send_data(8'h5A);
    chk("R6 raw second byte", last_byte, 8'h5A);
    send_data(8'h01);
    chk("R6 raw no parity flag", {last_byte, last_pe, last_se}, {8'h01, 1'b0, 1'b0});
    chk("R6 raw count", nbytes - n0, 3);
  endtask

  task automatic t_abort;
    int n0;
    set_mode(1, 0, 0);
    n0 = nbytes;
    send_bit(0); send_bit(1); send_bit(0); send_bit(1);
    chk("R7 busy mid byte", busy, 1);
    en = 1'b0;
    @(negedge clk);
    chk("R7 busy drops", busy, 0);
    en = 1'b1;
    send_frame(8'h66, 0, 0, 1);
    chk("R7 fresh framed byte", {last_byte, 8'(nbytes - n0)}, {8'h66, 8'd1});
    set_mode(0, 0, 0);
    n0 = nbytes;
    for (int i = 0; i < 5; i++) send_bit(i[0]);
    en = 1'b0;
    @(negedge clk);
    en = 1'b1;
    send_data(8'hC3);
    chk("R7 fresh raw byte", {last_byte, 8'(nbytes - n0)}, {8'hC3, 8'd1});
  endtask

  task automatic t_no_strobe;
    int n0;
    set_mode(1, 0, 0);
    n0 = nbytes;
    @(negedge clk);
    bit_d = 1'b0;
    repeat (4) @(negedge clk);
    chk("R8 unstrobed zero ignored", busy, 0);
    bit_d = 1'b1;
    send_frame(8'h9B, 0, 0, 1);
    chk("R8 frame after", {last_byte, 8'(nbytes - n0)}, {8'h9B, 8'd1});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_framed_basic();
    t_back_to_back();
    t_parity();
    t_stop_err();
    t_raw();
    t_abort();
    t_no_strobe();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule